// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

The block gathers interrupt events from a bank of GPIO pins organised as 21 groups of 8 pins, 168 pins in all. Each pin has its own trigger-mode field, a mask bit and a pending bit. Pin inputs are asynchronous. Each input passes through a two-flop synchroniser, and the synchronised value drives level or edge detection. A detected event sets the pin's pending bit whether or not the pin is masked. Software clears a pending bit by writing one to it.

A simple word-wide register bus reaches three banks: control, mask and pending. Each bank holds one 32-bit word per group, at a stride of 4 bytes. The block drives one combined interrupt line. It also gives the index of the highest-priority active pin. Priority runs from group 0 upward, and within a group from bit 0 upward, so a handler can service pins in that order without scanning.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The control word of group g (0..20) is at byte address 0x700+4g. The mask word is at 0x900+4g and the pending word at 0xA00+4g. A read request returns its data on `rdata_o` after the next rising clock edge. Bits [31:8] of mask and pending reads are zero.
- R2: Reset values: all control fields 0, all mask bits 1, all pending bits 0, `irq_o` low, `irq_id_o` zero and `rdata_o` zero.
- R3: Pin n of a group (pin index g*8+n on `pins_i`) takes its mode from control bits [4n+3:4n]. Mode 0 triggers on a low level, 1 on a high level, 2 on a falling edge, 3 on a rising edge and 4 on both edges.
- R4: Edge modes compare the synchronised input with its value one cycle earlier. A pin change driven before clock edge k becomes visible in the pending bit, and so on `irq_o`, after edge k+2 and not before.
- R5: In level modes the pending bit is set in every cycle that the level is active. A write-one clear has no lasting effect while the level persists. Pins held low in mode 0 after reset set their pending bits.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a trigger event occurs in the same cycle as the clear, the bit stays set. An edge-set bit stays set after the pin returns to its previous value.
- R7: `irq_o` is high while any pending bit has its mask bit at 0. A mask bit of 1 blocks the pin from `irq_o` but does not stop its pending bit from being set.
- R8: `irq_id_o` gives g*8+n of the active (pending and unmasked) pin with the lowest group, and the lowest bit within that group. It is zero when `irq_o` is low.
- R9: Reads from an offset outside the three banks, or from an address with bits [1:0] not zero, return zero. Writes to such an offset change no register.
- R10: Control field values 5 to 15 disable detection, so that pin never sets its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 168 | Asynchronous pin inputs, index g*8+n |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Combined interrupt request |
| irq_id_o | output | 8 | Index of highest-priority active pin |

## Verification
A wrong state in a pin's edge history or synchroniser shows up as a pending bit that appears one cycle early or late, or on the wrong transition. Unmasking the pin makes `irq_o` reveal this within three cycles of the pin change. A decode error shows at `rdata_o` on the read that follows, either as a wrong or aliased word or as a nonzero value from an unused offset. A wrong pending or mask bit changes `irq_id_o` at once, because the priority choice is combinational from those registers.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned CTRL_BASE = 32'h700;
  localparam int unsigned MASK_BASE = 32'h900;
  localparam int unsigned PEND_BASE = 32'hA00;
  localparam int unsigned FIELD_W   = 4;

  typedef enum logic [3:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;

  typedef enum logic [1:0] {
    BANK_NONE,
    BANK_CTRL,
    BANK_MASK,
    BANK_PEND
  } bank_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [FIELD_W-1:0] mode_i,
  input  logic               clr_i,
  output logic               pend_o
);
  logic prev_q, pend_q, set_evt, rise, fall;

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  always_comb begin
    case (mode_i)
      4'(TRIG_LOW):  set_evt = ~sync_i;
      4'(TRIG_HIGH): set_evt = sync_i;
      4'(TRIG_FALL): set_evt = fall;
      4'(TRIG_RISE): set_evt = rise;
      4'(TRIG_BOTH): set_evt = rise | fall;
      default:       set_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      pend_q <= (pend_q & ~clr_i) | set_evt;  // set wins over clear
    end
  end

  assign pend_o = pend_q;

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> pend_q);
  a_r6_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_evt) |=> !pend_q);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);
  a_r10_disabled_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i > 4'(TRIG_BOTH) && !pend_q) |=> !pend_q);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 21,
  parameter int unsigned GRP_PINS   = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic                                           req_i,
  input  logic                                           we_i,
  input  logic [ADDR_W-1:0]                              addr_i,
  input  logic [DATA_W-1:0]                              wdata_i,
  output logic [DATA_W-1:0]                              rdata_o,
  input  logic [NUM_GROUPS-1:0][GRP_PINS-1:0]            pend_i,
  output logic [NUM_GROUPS-1:0][GRP_PINS*FIELD_W-1:0]    ctrl_o,
  output logic [NUM_GROUPS-1:0][GRP_PINS-1:0]            mask_o,
  output logic [NUM_GROUPS-1:0][GRP_PINS-1:0]            clr_o
);
  localparam int unsigned GIDX_W = $clog2(NUM_GROUPS);
  localparam int unsigned CW     = GRP_PINS * FIELD_W;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_GROUPS * 4);

  logic [ADDR_W-1:0] rel_c, rel_m, rel_p;
  logic [GIDX_W-1:0] gsel;
  bank_e             bank;
  logic              aligned, hit;

  logic [NUM_GROUPS-1:0][CW-1:0]       ctrl_q;
  logic [NUM_GROUPS-1:0][GRP_PINS-1:0] mask_q;

  assign rel_c   = addr_i - ADDR_W'(CTRL_BASE);
  assign rel_m   = addr_i - ADDR_W'(MASK_BASE);
  assign rel_p   = addr_i - ADDR_W'(PEND_BASE);
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    bank = BANK_NONE;
    gsel = '0;
    if (aligned) begin
      if (rel_c < SPAN) begin
        bank = BANK_CTRL;
        gsel = rel_c[GIDX_W+1:2];
      end else if (rel_m < SPAN) begin
        bank = BANK_MASK;
        gsel = rel_m[GIDX_W+1:2];
      end else if (rel_p < SPAN) begin
        bank = BANK_PEND;
        gsel = rel_p[GIDX_W+1:2];
      end
    end
  end

  assign hit = (bank != BANK_NONE);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = req_i && we_i && (gsel == GIDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[g] <= '0;
        mask_q[g] <= '1;
      end else if (sel) begin
        if (bank == BANK_CTRL) ctrl_q[g] <= wdata_i[CW-1:0];
        if (bank == BANK_MASK) mask_q[g] <= wdata_i[GRP_PINS-1:0];
      end
    end

    assign clr_o[g] = (sel && bank == BANK_PEND) ? wdata_i[GRP_PINS-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (req_i && !we_i) begin
      case (bank)
        BANK_CTRL: rdata_o <= DATA_W'(ctrl_q[gsel]);
        BANK_MASK: rdata_o <= DATA_W'(mask_q[gsel]);
        BANK_PEND: rdata_o <= DATA_W'(pend_i[gsel]);
        default:   rdata_o <= '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;

  a_r9_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |=> (rdata_o == '0));
  a_r9_unmapped_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !hit) |=> ($stable(ctrl_q) && $stable(mask_q)));
  a_r1_upper_mask_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && bank == BANK_MASK) |=> (rdata_o[DATA_W-1:GRP_PINS] == '0));
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int unsigned N    = 168,
  parameter int unsigned ID_W = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i);  // lowest index wins
    end
  end

  assign valid_o = |req_i;

  a_r8_no_lower_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((req_i & ((N'(1) << id_o) - N'(1))) == '0));
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (id_o == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 21,
  parameter int unsigned GRP_PINS   = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned NUM_PINS  = NUM_GROUPS * GRP_PINS,
  localparam int unsigned ID_W      = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o,
  output logic [ID_W-1:0]     irq_id_o
);
  logic [NUM_PINS-1:0] pins_s;
  logic [NUM_GROUPS-1:0][GRP_PINS*FIELD_W-1:0] ctrl;
  logic [NUM_GROUPS-1:0][GRP_PINS-1:0] mask, pend, clr;
  logic [NUM_PINS-1:0] pend_flat, mask_flat, active;

  gpio_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  gpio_irq_regs #(
    .NUM_GROUPS(NUM_GROUPS),
    .GRP_PINS  (GRP_PINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .pend_i (pend),
    .ctrl_o (ctrl),
    .mask_o (mask),
    .clr_o  (clr)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar p = 0; p < GRP_PINS; p++) begin : g_pin
      gpio_irq_trig u_trig (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sync_i(pins_s[g*GRP_PINS+p]),
        .mode_i(ctrl[g][p*FIELD_W +: FIELD_W]),
        .clr_i (clr[g][p]),
        .pend_o(pend[g][p])
      );
    end
  end

  assign pend_flat = pend;
  assign mask_flat = mask;
  assign active    = pend_flat & ~mask_flat;

  gpio_irq_prio #(.N(NUM_PINS), .ID_W(ID_W)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (active),
    .valid_o(irq_o),
    .id_o   (irq_id_o)
  );

  a_r8_id_is_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_flat[irq_id_o] && !mask_flat[irq_id_o]));
  a_r7_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_flat) |-> !irq_o);
  a_r7_unmasked_pending_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_flat & ~mask_flat)) |-> irq_o);
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 168;
  localparam int NV = 14;

  // row: {we, addr, wdata, expected read}
  localparam logic [76:0] VECS [NV] = '{
    {1'b0, 12'h700, 32'h0,        32'h0},         // R2 ctrl reset
    {1'b0, 12'h950, 32'h0,        32'h0000_00FF}, // R2 mask reset, group 20
    {1'b1, 12'h704, 32'h1234_5678, 32'h0},
    {1'b0, 12'h704, 32'h0,        32'h1234_5678}, // R3 field readback
    {1'b1, 12'h910, 32'hFFFF_FF5A, 32'h0},
    {1'b0, 12'h910, 32'h0,        32'h0000_005A}, // R1 upper bits zero
    {1'b0, 12'h954, 32'h0,        32'h0},         // R9 past mask bank
    {1'b1, 12'h754, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h754, 32'h0,        32'h0},         // R9 past ctrl bank
    {1'b0, 12'h750, 32'h0,        32'h0},         // R1 group 20 ctrl
    {1'b0, 12'h702, 32'h0,        32'h0},         // R9 misaligned
    {1'b1, 12'h800, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h700, 32'h0,        32'h0},         // R9 write ignored
    {1'b0, 12'hA00, 32'h0,        32'h0000_00FF}  // R5 low level after reset
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  logic [7:0]    irq_id;
  int            checks = 0, errors = 0;
  logic [31:0]   rd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_irq_ctrl uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .pins_i  (pins),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq),
    .irq_id_o(irq_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 irq in reset", 32'(irq), 32'h0);
    chk("R2 rdata in reset", rdata, 32'h0);
    chk("R2 id in reset", 32'(irq_id), 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][76]) bus_wr(VECS[i][75:64], VECS[i][63:32]);
      else begin
        bus_rd(VECS[i][75:64], rd);
        chk($sformatf("table row %0d (R1/R2/R9)", i), rd, VECS[i][31:0]);
      end
    end

    // quiet state: all pins disabled, masked, cleared
    for (int g = 0; g < 21; g++) begin
      bus_wr(12'(12'h700 + 4 * g), 32'h7777_7777);
      bus_wr(12'(12'h900 + 4 * g), 32'hFF);
      bus_wr(12'(12'hA00 + 4 * g), 32'hFF);
    end
    bus_rd(12'hA10, rd);
    chk("R6 pending cleared", rd, 32'h0);
    chk("R7 irq after clear", 32'(irq), 32'h0);

    // R4 rising edge with latency, group 2 pin 3 (index 19)
    bus_wr(12'h708, 32'h7777_3777);
    bus_wr(12'h908, 32'hF7);
    @(negedge clk); pins[19] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 not visible after two edges", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R4 visible after third edge", 32'(irq), 32'h1);
    chk("R8 id single pin", 32'(irq_id), 32'd19);
    bus_rd(12'hA08, rd);
    chk("R3 rise pending word", rd, 32'h08);
    pins[19] = 1'b0; settle();
    bus_rd(12'hA08, rd);
    chk("R6 edge bit sticky", rd, 32'h08);
    bus_wr(12'hA08, 32'h0);
    bus_rd(12'hA08, rd);
    chk("R6 write zero no effect", rd, 32'h08);
    bus_wr(12'hA08, 32'h08);
    bus_rd(12'hA08, rd);
    chk("R6 write one clears", rd, 32'h0);
    chk("R7 irq drops on clear", 32'(irq), 32'h0);

    // falling edge
    bus_wr(12'h708, 32'h7777_2777);
    pins[19] = 1'b1; settle();
    bus_rd(12'hA08, rd);
    chk("R3 fall ignores rise", rd, 32'h0);
    pins[19] = 1'b0; settle();
    bus_rd(12'hA08, rd);
    chk("R3 fall sets", rd, 32'h08);
    bus_wr(12'hA08, 32'h08);

    // both edges
    bus_wr(12'h708, 32'h7777_4777);
    pins[19] = 1'b1; settle();
    bus_rd(12'hA08, rd);
    chk("R3 both on rise", rd, 32'h08);
    bus_wr(12'hA08, 32'h08);
    pins[19] = 1'b0; settle();
    bus_rd(12'hA08, rd);
    chk("R3 both on fall", rd, 32'h08);
    bus_wr(12'hA08, 32'h08);

    // R5 level high
    bus_wr(12'h708, 32'h7777_1777);
    bus_rd(12'hA08, rd);
    chk("R5 high level idle", rd, 32'h0);
    pins[19] = 1'b1; settle();
    bus_wr(12'hA08, 32'h08);
    bus_rd(12'hA08, rd);
    chk("R5 level re-sets after clear", rd, 32'h08);
    pins[19] = 1'b0; settle();
    bus_wr(12'hA08, 32'h08);
    bus_rd(12'hA08, rd);
    chk("R5 clear after level gone", rd, 32'h0);

    // R7 mask blocks output, not capture
    bus_wr(12'h708, 32'h7777_3777);
    bus_wr(12'h908, 32'hFF);
    pins[19] = 1'b1; settle();
    bus_rd(12'hA08, rd);
    chk("R7 masked pin still captured", rd, 32'h08);
    chk("R7 masked irq low", 32'(irq), 32'h0);
    bus_wr(12'h908, 32'hF7);
    chk("R7 unmask raises irq", 32'(irq), 32'h1);
    bus_wr(12'h908, 32'hFF);
    bus_wr(12'hA08, 32'h08);
    pins[19] = 1'b0;

    // R8 priority: group 3 pin 6 (30) over group 7 pin 0 (56)
    bus_wr(12'h70C, 32'h7377_7777);
    bus_wr(12'h71C, 32'h7777_7773);
    bus_wr(12'h90C, 32'hBF);
    bus_wr(12'h91C, 32'hFE);
    pins[30] = 1'b1; pins[56] = 1'b1; settle();
    chk("R8 lowest group wins", 32'(irq_id), 32'd30);
    bus_wr(12'hA0C, 32'h40);
    chk("R8 next after clear", 32'(irq_id), 32'd56);
    bus_wr(12'hA1C, 32'h01);
    chk("R8 idle id zero", 32'(irq_id), 32'd0);
    chk("R8 idle irq low", 32'(irq), 32'h0);

    // R10 disabled modes
    pins[47:40] = 8'hFF; settle();
    pins[47:40] = 8'h00; settle();
    bus_rd(12'hA14, rd);
    chk("R10 mode 7 no capture", rd, 32'h0);
    bus_wr(12'h714, 32'hFFFF_FFFF);
    pins[47:40] = 8'hFF; settle();
    pins[47:40] = 8'h00; settle();
    bus_rd(12'hA14, rd);
    chk("R10 mode 15 no capture", rd, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule